// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block decides, for every bus access, whether the access may proceed. The access is described by its address, the number of the master that issues it (0 to 7), its kind (data read, data write or instruction fetch), the privilege level and a process identifier. A set of region descriptors is compared against the access. Each descriptor holds an address window at 32-byte granularity, a packed word of rights for each master, a process identifier with a don't-care mask, and a valid flag. The descriptors come in as flat input vectors, and whatever fills them sits outside this block.

Masters 0 to 3 are privileged. Each has a 6-bit field in the rights word. The field holds a 3-bit user read/write/execute mask, a 2-bit supervisor code and a process-ID enable flag. Masters 4 to 7 have only a read enable and a write enable, packed from bit 24 upward. An access is allowed when at least one valid region that matches it grants the kind of access requested. A denied access is reported as one of three classes: no region matched, a single region matched but refused, or several overlapping regions matched and all of them refused.

The verdict is registered. It appears one clock after the access strobe, together with the hit vector and the error class, and it holds until the next strobe. A global enable input turns checking off, and every access is then allowed.

Top module: `mpu_region_checker`

## Requirements
- R1: A region's start address is used with bits 4:0 cleared and its end address with bits 4:0 set. An access address matches the window when it lies between these two values, both ends included.
- R2: For a master 0..3 in user mode, the 6-bit field at bit 6×n of the rights word supplies the user mask in bits 2:0, with read in bit 2, write in bit 1 and execute in bit 0. The access kind is coded as 0 = read, 1 = write, 2 = fetch. Kind 3 is never granted.
- R3: For a master 0..3 in supervisor mode, the field's bits 4:3 select the rights. 0 allows read, write and fetch. 1 allows read and fetch. 2 allows read and write. 3 applies the user mask of R2.
- R4: For a master n of 4..7, the 2-bit field at bit 24+2×(n−4) holds write enable in bit 0 and read enable in bit 1. A fetch by these masters is never granted.
- R5: When bit 5 of a master 0..3 field is set, that region matches only if the access PID equals the region PID in every bit that is clear in the region's mask. For masters 4..7 the PID has no effect.
- R6: A region whose valid input is 0 never appears in the hit vector and never grants.
- R7: When the global enable is 0, the access is granted with a zero hit vector and error class 0.
- R8: An access is granted when any matching region grants its kind, even if other matching regions refuse it.
- R9: The error class is 0 when granted, 1 when no region matched, 2 when exactly one region matched and refused, and 3 when two or more regions matched and all refused.
- R10: rsp_valid is high exactly in the cycle after an access strobe. Grant, hit vector and error class change only in that cycle and otherwise hold.
- R11: After reset, rsp_valid, rsp_grant, rsp_hit and rsp_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global checking enable |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access address |
| acc_master | input | 3 | Issuing master number |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| acc_super | input | 1 | 1 = supervisor mode |
| acc_pid | input | PID_W | Process identifier of the access |
| rg_valid | input | NUM_REGIONS | Per-region valid flags |
| rg_start | input | NUM_REGIONS*ADDR_W | Region start addresses, region r at bits r*ADDR_W |
| rg_end | input | NUM_REGIONS*ADDR_W | Region end addresses |
| rg_rights | input | NUM_REGIONS*32 | Packed master rights words |
| rg_pid | input | NUM_REGIONS*PID_W | Region process identifiers |
| rg_pid_mask | input | NUM_REGIONS*PID_W | PID don't-care masks (1 = ignore bit) |
| rsp_valid | output | 1 | Verdict valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_hit | output | NUM_REGIONS | Regions that matched |
| rsp_err | output | 2 | Error class per R9 |

## Verification
The bench aims at the edges of the window: the last byte before a start, the last byte of the forced end block, and descriptors whose low address bits are junk. A design that trusted those bits would match or miss by up to 31 bytes. It also covers supervisor code 3, which must fall back to the user mask, and the masked PID compare. A design that inverted the mask sense, or gated masters 4..7 by PID, would drop hits. Overlap cases where only one region grants catch an AND-across-regions design. Overlap cases where none grants catch a classification that mistakes class 2 for class 3. A long random phase compares every response against a behavioural model.

// File: rtl/mpu_region_checker.sv
module mpu_region_checker #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int PID_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          glb_en,
  input  logic                          acc_valid,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [2:0]                    acc_master,
  input  logic [1:0]                    acc_type,
  input  logic                          acc_super,
  input  logic [PID_W-1:0]              acc_pid,
  input  logic [NUM_REGIONS-1:0]        rg_valid,
  input  logic [NUM_REGIONS*ADDR_W-1:0] rg_start,
  input  logic [NUM_REGIONS*ADDR_W-1:0] rg_end,
  input  logic [NUM_REGIONS*32-1:0]     rg_rights,
  input  logic [NUM_REGIONS*PID_W-1:0]  rg_pid,
  input  logic [NUM_REGIONS*PID_W-1:0]  rg_pid_mask,
  output logic                          rsp_valid,
  output logic                          rsp_grant,
  output logic [NUM_REGIONS-1:0]        rsp_hit,
  output logic [1:0]                    rsp_err
);
  localparam int RW = 32;
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'(31);

  logic [NUM_REGIONS-1:0] hit, allow;
  logic                   priv;

  assign priv = ~acc_master[2];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic [ADDR_W-1:0] lo, hi;
    logic [RW-1:0]     rw;
    logic [5:0]        pf;
    logic [1:0]        nf;
    logic [PID_W-1:0]  rp, rm;
    logic              in_rng, pid_ok;
    logic [2:0]        rwx;

    assign lo = rg_start[r*ADDR_W +: ADDR_W] & ~BLK_MASK;
    assign hi = rg_end[r*ADDR_W +: ADDR_W] | BLK_MASK;
    assign rw = rg_rights[r*RW +: RW];
    assign rp = rg_pid[r*PID_W +: PID_W];
    assign rm = rg_pid_mask[r*PID_W +: PID_W];
    assign pf = rw[6*acc_master[1:0] +: 6];
    assign nf = rw[24 + 2*acc_master[1:0] +: 2];

    assign in_rng = (acc_addr >= lo) && (acc_addr <= hi);
    assign pid_ok = !(priv && pf[5]) || (((acc_pid ^ rp) & ~rm) == '0);
    assign hit[r] = rg_valid[r] && in_rng && pid_ok;

    always_comb begin
      if (!priv)
        rwx = {nf[1], nf[0], 1'b0};
      else if (acc_super && pf[4:3] != 2'd3)
        case (pf[4:3])
          2'd0:    rwx = 3'b111;
          2'd1:    rwx = 3'b101;
          default: rwx = 3'b110;
        endcase
      else
        rwx = pf[2:0];
    end

    always_comb
      case (acc_type)
        2'd0:    allow[r] = rwx[2];
        2'd1:    allow[r] = rwx[1];
        2'd2:    allow[r] = rwx[0];
        default: allow[r] = 1'b0;
      endcase
  end

  logic       granted;
  logic [1:0] err_cls;
  logic [$clog2(NUM_REGIONS+1)-1:0] nhit;

  assign nhit    = $bits(nhit)'($countones(hit));
  assign granted = !glb_en || |(hit & allow);
  assign err_cls = granted   ? 2'd0 :
                   nhit == 0 ? 2'd1 :
                   nhit == 1 ? 2'd2 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_hit   <= '0;
      rsp_err   <= 2'd0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid) begin
        rsp_grant <= granted;
        rsp_hit   <= glb_en ? hit : '0;
        rsp_err   <= err_cls;
      end
    end
  end

  a_r10_strobe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid && $stable(rsp_grant) && $stable(rsp_hit) && $stable(rsp_err));
  a_r7_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !glb_en |=> rsp_grant && rsp_hit == '0 && rsp_err == 2'd0);
  a_r6_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (rsp_hit & ~$past(rg_valid)) == '0);
  a_r9_nohit_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_grant && rsp_hit == '0 |-> rsp_err == 2'd1);
  a_r9_overlap_class: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_grant && $countones(rsp_hit) > 1 |-> rsp_err == 2'd3);
  a_r8_grant_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && glb_en |=> !rsp_grant || rsp_hit != '0);
endmodule

// File: tb/test_mpu_region_checker.sv
module test_mpu_region_checker;
  localparam int NR = 8, AW = 32, PW = 8;

  logic clk = 0, rst_n = 0, glb_en = 1, acc_valid = 0, acc_super = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0] acc_master = '0;
  logic [1:0] acc_type = '0;
  logic [PW-1:0] acc_pid = '0;
  logic [NR-1:0] rg_valid = '0;
  logic [NR*AW-1:0] rg_start = '0, rg_end = '0;
  logic [NR*32-1:0] rg_rights = '0;
  logic [NR*PW-1:0] rg_pid = '0, rg_pid_mask = '0;
  logic rsp_valid, rsp_grant;
  logic [NR-1:0] rsp_hit;
  logic [1:0] rsp_err;

  int checks = 0, fails = 0;
  bit done = 0;

  mpu_region_checker #(.NUM_REGIONS(NR), .ADDR_W(AW), .PID_W(PW)) i_mpu_region_checker (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_master(acc_master), .acc_type(acc_type), .acc_super(acc_super), .acc_pid(acc_pid),
    .rg_valid(rg_valid), .rg_start(rg_start), .rg_end(rg_end), .rg_rights(rg_rights),
    .rg_pid(rg_pid), .rg_pid_mask(rg_pid_mask), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .rsp_hit(rsp_hit), .rsp_err(rsp_err));

  always #5 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] privf(int m, int user, int sup, int pe);
    return 32'((pe << 5) | (sup << 3) | user) << (6 * m);
  endfunction

  function automatic logic [31:0] rwf(int m, int rd, int wr);
    return 32'((rd << 1) | wr) << (24 + 2 * (m - 4));
  endfunction

  task automatic set_rgn(int r, logic [31:0] s, logic [31:0] e, logic [31:0] rights,
                         logic [7:0] pid, logic [7:0] mask, bit v);
    rg_start[r*AW +: AW] = s;
    rg_end[r*AW +: AW] = e;
    rg_rights[r*32 +: 32] = rights;
    rg_pid[r*PW +: PW] = pid;
    rg_pid_mask[r*PW +: PW] = mask;
    rg_valid[r] = v;
  endtask

  function automatic void model(output bit g, output logic [NR-1:0] h, output int e);
    int n;
    n = 0; g = 0; h = '0; e = 0;
    if (!glb_en) begin g = 1; return; end
    for (int r = 0; r < NR; r++) begin
      logic [31:0] lo, hi, rw;
      logic [5:0] f;
      logic [1:0] sf;
      bit rd, wr, ex, pidok;
      lo = rg_start[r*AW +: AW] & ~32'h1f;
      hi = rg_end[r*AW +: AW] | 32'h1f;
      rw = rg_rights[r*32 +: 32];
      pidok = 1;
      if (acc_master < 4) begin
        f = 6'((rw >> (6 * acc_master)) & 63);
        if (f[5] && (((acc_pid ^ rg_pid[r*PW +: PW]) & ~rg_pid_mask[r*PW +: PW]) != 0)) pidok = 0;
        sf = f[4:3];
        if (acc_super && sf != 3) begin
          rd = 1; wr = (sf != 1); ex = (sf != 2);
        end else begin
          rd = f[2]; wr = f[1]; ex = f[0];
        end
      end else begin
        f = 6'((rw >> (24 + 2 * (acc_master - 4))) & 3);
        rd = f[1]; wr = f[0]; ex = 0;
      end
      if (rg_valid[r] && acc_addr >= lo && acc_addr <= hi && pidok) begin
        h[r] = 1; n++;
        if ((acc_type == 0 && rd) || (acc_type == 1 && wr) || (acc_type == 2 && ex)) g = 1;
      end
    end
    e = g ? 0 : (n == 0 ? 1 : (n == 1 ? 2 : 3));
  endfunction

  task automatic acc(input string tag, logic [31:0] a, int m, int t, bit sup, logic [7:0] pid);
    bit eg; logic [NR-1:0] eh; int ee;
    acc_addr = a; acc_master = 3'(m); acc_type = 2'(t); acc_super = sup; acc_pid = pid;
    acc_valid = 1;
    model(eg, eh, ee);
    @(negedge clk);
    acc_valid = 0;
    chk(tag, "valid", 32'(rsp_valid), 1);
    chk(tag, "grant", 32'(rsp_grant), 32'(eg));
    chk(tag, "hit", 32'(rsp_hit), 32'(eh));
    chk(tag, "err", 32'(rsp_err), 32'(ee));
  endtask

  task automatic idle(input string tag);
    logic g0; logic [NR-1:0] h0; logic [1:0] e0;
    g0 = rsp_grant; h0 = rsp_hit; e0 = rsp_err;
    acc_valid = 0;
    acc_addr = acc_addr ^ 32'h1000;
    @(negedge clk);
    chk(tag, "valid_idle", 32'(rsp_valid), 0);
    chk(tag, "hold", {rsp_err, rsp_hit, rsp_grant}, {e0, h0, g0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "valid", 32'(rsp_valid), 0);
    chk("R11", "grant", 32'(rsp_grant), 0);
    chk("R11", "hit", 32'(rsp_hit), 0);
    chk("R11", "err", 32'(rsp_err), 0);
    rst_n = 1;
    @(negedge clk);

    set_rgn(0, 32'h101F, 32'h1F00, privf(0,4,3,0) | rwf(4,1,0), 0, 0, 1);
    set_rgn(1, 32'h2000, 32'h2FE0, privf(0,3,1,0) | privf(1,0,2,0) | privf(2,0,0,0) | rwf(5,0,1) | rwf(7,1,0), 0, 0, 1);
    set_rgn(2, 32'h2800, 32'h37FF, privf(0,7,3,0) | privf(1,0,3,0) | privf(3,7,3,1) | rwf(4,1,0), 8'h5A, 8'h0F, 1);
    set_rgn(3, 32'h0, 32'hFFFF_FFFF, {8{4'hF}}, 0, 0, 0);

    acc("R1", 32'h1000, 0, 0, 0, 0);
    acc("R1", 32'h1F1F, 0, 0, 0, 0);
    acc("R1", 32'h1F20, 0, 0, 0, 0);
    acc("R1", 32'h0FFF, 0, 0, 0, 0);
    acc("R2", 32'h1000, 0, 1, 0, 0);
    acc("R2", 32'h1000, 0, 2, 0, 0);
    acc("R2", 32'h1000, 0, 3, 0, 0);
    acc("R2", 32'h2100, 0, 1, 0, 0);
    acc("R2", 32'h2100, 0, 0, 0, 0);
    acc("R3", 32'h1000, 0, 0, 1, 0);
    acc("R3", 32'h1000, 0, 1, 1, 0);
    acc("R3", 32'h2100, 0, 1, 1, 0);
    acc("R3", 32'h2100, 0, 2, 1, 0);
    acc("R3", 32'h2100, 1, 0, 1, 0);
    acc("R3", 32'h2100, 1, 2, 1, 0);
    acc("R3", 32'h2100, 2, 1, 1, 0);
    acc("R3", 32'h2100, 2, 0, 0, 0);
    acc("R4", 32'h1000, 4, 0, 0, 0);
    acc("R4", 32'h1000, 4, 1, 0, 0);
    acc("R4", 32'h1000, 4, 2, 1, 0);
    acc("R4", 32'h2100, 5, 1, 0, 0);
    acc("R4", 32'h2100, 5, 0, 0, 0);
    acc("R4", 32'h2100, 7, 0, 0, 0);
    acc("R4", 32'h2100, 6, 0, 0, 0);
    acc("R5", 32'h3000, 3, 0, 0, 8'h53);
    acc("R5", 32'h3000, 3, 0, 0, 8'h6A);
    acc("R5", 32'h2900, 3, 0, 0, 8'h6A);
    acc("R5", 32'h3000, 4, 0, 0, 8'hFF);
    acc("R8", 32'h2900, 0, 0, 0, 0);
    acc("R9", 32'h2900, 1, 0, 0, 0);
    acc("R6", 32'h8000, 0, 0, 0, 0);
    rg_valid[3] = 1;
    acc("R6", 32'h8000, 0, 0, 0, 0);
    rg_valid[3] = 0;
    acc("R6", 32'h1000, 0, 1, 0, 0);
    glb_en = 0;
    acc("R7", 32'h8000, 0, 0, 0, 0);
    acc("R7", 32'h1000, 6, 3, 0, 0);
    glb_en = 1;
    idle("R10");
    idle("R10");

    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0)
        for (int r = 0; r < NR; r++) begin
          logic [31:0] s;
          s = $urandom_range(0, 32'h3000);
          set_rgn(r, s, s + $urandom_range(0, 32'h1000), $urandom, 8'($urandom), 8'($urandom), 1'($urandom));
        end
      glb_en = ($urandom_range(0, 15) != 0);
      if ($urandom_range(0, 5) == 0) idle("R10");
      else acc("R8", $urandom_range(0, 32'h4000), $urandom_range(0, 7), $urandom_range(0, 3),
               1'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule